// File: doc/BRIEF.md
# PCIe Completion Header Validator

This block sits on the receive side of a PCIe port, between the transaction layer and the logic that issued non-posted programmed-I/O requests. When such a request leaves the chip, its requester records the fields it expects to see echoed back, in an entry of a small table indexed by tag. Those fields are the request kind, requester ID, length, traffic class, attributes, lower address and expected byte count. Each arriving completion header is then matched against the table. The block returns one of five verdicts: forward as good, drop as unexpected, drop as malformed, drop as configuration retry, or forward with its status rewritten to Unsupported Request.

A 64-bit diagnostic control word can switch off five of the checks one by one. A completion whose only failures are switched-off checks passes as if it were good. When a tag is retired, the block reports it. A timeout input lets the external timer release an entry that will never be answered.

The sequencer has two states. In IDLE, `cpl_ready` is high. The transition IDLE→EVAL is taken when a header is accepted. In EVAL, the held header is judged against the table, and the transition EVAL→IDLE is taken unconditionally. The registered verdict pulses appear in the cycle that follows EVAL.

Top module: `cplv_validator`

## Requirements
- R1: The header is a 96-bit record. Its fields are: completer ID [15:0], lower address [22:16], tag [30:23], requester ID [46:31], byte count [58:47], status [61:59], length [71:62], attributes [73:72], traffic class [76:74], locked flag [77] and data-present flag [78]. Bits [95:79] are reserved. `cpl_ready` is high in IDLE and low in the cycle after a header is accepted. The verdict outputs pulse for exactly one cycle, one cycle after that.
- R2: A request allocates its tag entry unless it is a memory write. Request kind codes are memory=0, I/O=1, config type 0=2 and config type 1=3. A memory write allocates nothing, so a later completion on its tag is unexpected.
- R3: A completion is unexpected when any of these holds: no valid entry exists for its tag, a tag bit above the table index is set, its requester ID differs from the recorded one, or its locked flag is set. Such a completion raises `err_unexp`, is not forwarded, and leaves the entry pending.
- R4: A completion that is not unexpected is malformed when any of these holds. Its status is not one of SC=000, UR=001, CRS=010 or CA=100. Its data-present flag differs from "status SC and request is a read". Or its length differs from the recorded length when it carries data, or from 0 when it does not.
- R5: A traffic class, attribute, byte-count or lower-address mismatch makes a completion malformed. It raises `err_malf`, is dropped, and leaves the entry pending.
- R6: A CRS completion to a configuration request with every other check passing raises `err_retry` and is dropped.
- R7: A CRS completion to a memory or I/O request is malformed while the CRS check is enabled.
- R8: Diagnostic bits 40, 41, 42, 43 and 44 disable the CRS, traffic-class, attribute, byte-count and lower-address checks respectively. A completion that fails only disabled checks is forwarded.
- R9: With the CRS check disabled, a CRS completion to a memory or I/O request is forwarded with status UR and its tag is freed. It pulses `err_wuc` if the request was a write, or `err_ruc` if it was a read.
- R10: A good completion is forwarded unchanged on `fwd_hdr`, pulses `free_valid` with its tag, and clears the entry, so that a repeat is unexpected.
- R11: `tmo_valid` clears the entry for `tmo_tag`; a later completion on that tag is unexpected.
- R12: At most one of the five error pulses is raised per completion. A good completion raises none.
- R13: Every error pulse loads `err_log_hdr` with the header as received, with its original status. It is unchanged otherwise.
- R14: After reset, `cpl_ready` is high, all pulses are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A non-posted request is issued this cycle |
| req_tag | input | 3 | Table index of the request |
| req_write | input | 1 | Request is a write |
| req_kind | input | 2 | Request kind code |
| req_rid | input | 16 | Requester ID |
| req_len | input | 10 | Length in dwords |
| req_tc | input | 3 | Traffic class |
| req_attr | input | 2 | Attributes |
| req_laddr | input | 7 | Expected lower address |
| req_bcnt | input | 12 | Expected byte count |
| tmo_valid | input | 1 | Timeout for an outstanding request |
| tmo_tag | input | 3 | Tag that timed out |
| diag_ctl | input | 64 | Diagnostic control word (check disables) |
| cpl_valid | input | 1 | Completion header offered |
| cpl_ready | output | 1 | Header can be accepted |
| cpl_hdr | input | 96 | Completion header |
| fwd_valid | output | 1 | Completion forwarded |
| fwd_hdr | output | 96 | Forwarded header |
| free_valid | output | 1 | Tag retired |
| free_tag | output | 3 | Retired tag |
| err_unexp | output | 1 | Unexpected completion |
| err_malf | output | 1 | Malformed completion |
| err_retry | output | 1 | Configuration retry |
| err_wuc | output | 1 | Remapped CRS on a write request |
| err_ruc | output | 1 | Remapped CRS on a read request |
| err_log_hdr | output | 96 | Header captured on the last error |

## Verification
A wrong table entry shows up at the ports on the next completion to that tag. The completion is reported as unexpected where it should have been forwarded, or it is forwarded where it should have been dropped, two cycles after the header is accepted. A stuck sequencer shows at once: `cpl_ready` stays low, or a verdict pulse is missing. A bad check mask swaps malformed for forwarded verdicts. A bad status rewrite shows as a wrong status field in `fwd_hdr`. A stale log shows as a mismatch with the header that caused the error.

// File: rtl/cplv_pkg.sv
package cplv_pkg;

    localparam int HDR_W = 96;
    localparam int NCHK  = 5;

    // check positions inside the disable field
    localparam int CHK_CRS   = 0;
    localparam int CHK_TC    = 1;
    localparam int CHK_ATTR  = 2;
    localparam int CHK_BCNT  = 3;
    localparam int CHK_LADDR = 4;

    localparam logic [2:0] CS_SC  = 3'b000;
    localparam logic [2:0] CS_UR  = 3'b001;
    localparam logic [2:0] CS_CRS = 3'b010;
    localparam logic [2:0] CS_CA  = 3'b100;

    typedef enum logic [1:0] {
        RK_MEM  = 2'd0,
        RK_IO   = 2'd1,
        RK_CFG0 = 2'd2,
        RK_CFG1 = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic [16:0] rsvd;
        logic        has_data;
        logic        locked;
        logic [2:0]  tc;
        logic [1:0]  attr;
        logic [9:0]  len;
        logic [2:0]  status;
        logic [11:0] bcnt;
        logic [15:0] rid;
        logic [7:0]  tag;
        logic [6:0]  laddr;
        logic [15:0] cid;
    } cpl_hdr_t;

    typedef struct packed {
        logic        valid;
        logic        is_write;
        req_kind_e   kind;
        logic [15:0] rid;
        logic [9:0]  len;
        logic [2:0]  tc;
        logic [1:0]  attr;
        logic [6:0]  laddr;
        logic [11:0] bcnt;
    } pend_ent_t;

    typedef enum logic [2:0] {
        VR_GOOD  = 3'd0,
        VR_UNEXP = 3'd1,
        VR_MALF  = 3'd2,
        VR_RETRY = 3'd3,
        VR_REMAP = 3'd4
    } verdict_e;

endpackage

// File: rtl/cplv_tag_table.sv
module cplv_tag_table
    import cplv_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  pend_ent_t        alloc_ent,
    input  logic             rel_a_en,
    input  logic [TAG_W-1:0] rel_a_tag,
    input  logic             rel_b_en,
    input  logic [TAG_W-1:0] rel_b_tag,
    input  logic [TAG_W-1:0] look_tag,
    output pend_ent_t        look_ent
);

    localparam int DEPTH = 1 << TAG_W;

    pend_ent_t ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic hit_alloc;
        logic hit_rel;
        assign hit_alloc = alloc_en && (alloc_tag == TAG_W'(i));
        assign hit_rel   = (rel_a_en && (rel_a_tag == TAG_W'(i))) ||
                           (rel_b_en && (rel_b_tag == TAG_W'(i)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (hit_alloc) begin
                ent_q[i] <= alloc_ent;
            end else if (hit_rel) begin
                ent_q[i].valid <= 1'b0;
            end
        end
    end

    assign look_ent = ent_q[look_tag];

endmodule

// File: rtl/cplv_field_check.sv
module cplv_field_check
    import cplv_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  cpl_hdr_t        hdr,
    input  pend_ent_t       ent,
    input  logic [NCHK-1:0] chk_off,
    output verdict_e        verdict,
    output cpl_hdr_t        out_hdr
);

    logic            tag_hit;
    logic            is_unexp;
    logic            is_cfg;
    logic            is_crs;
    logic            st_legal;
    logic            want_data;
    logic            core_bad;
    logic [NCHK-1:0] opt_fail;
    logic [NCHK-1:0] opt_live;

    always_comb begin
        tag_hit   = ent.valid && ((hdr.tag >> TAG_W) == 8'd0);
        is_unexp  = !tag_hit || (hdr.rid != ent.rid) || hdr.locked;
        is_cfg    = (ent.kind == RK_CFG0) || (ent.kind == RK_CFG1);
        is_crs    = (hdr.status == CS_CRS);
        st_legal  = (hdr.status == CS_SC) || (hdr.status == CS_UR) ||
                    (hdr.status == CS_CRS) || (hdr.status == CS_CA);
        want_data = (hdr.status == CS_SC) && !ent.is_write;

        core_bad = !st_legal ||
                   (hdr.has_data != want_data) ||
                   (hdr.has_data ? (hdr.len != ent.len) : (hdr.len != 10'd0));

        opt_fail[CHK_CRS]   = is_crs && !is_cfg;
        opt_fail[CHK_TC]    = hdr.tc    != ent.tc;
        opt_fail[CHK_ATTR]  = hdr.attr  != ent.attr;
        opt_fail[CHK_BCNT]  = hdr.bcnt  != ent.bcnt;
        opt_fail[CHK_LADDR] = hdr.laddr != ent.laddr;
        opt_live = opt_fail & ~chk_off;

        if (is_unexp) begin
            verdict = VR_UNEXP;
        end else if (core_bad || (|opt_live)) begin
            verdict = VR_MALF;
        end else if (is_crs && is_cfg) begin
            verdict = VR_RETRY;
        end else if (is_crs) begin
            verdict = VR_REMAP;
        end else begin
            verdict = VR_GOOD;
        end

        out_hdr = hdr;
        if (verdict == VR_REMAP) begin
            out_hdr.status = CS_UR;
        end
    end

endmodule

// File: rtl/cplv_validator.sv
module cplv_validator
    import cplv_pkg::*;
#(
    parameter int TAG_W     = 3,
    parameter int DIAG_W    = 64,
    parameter int DIAG_BASE = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_write,
    input  logic [1:0]        req_kind,
    input  logic [15:0]       req_rid,
    input  logic [9:0]        req_len,
    input  logic [2:0]        req_tc,
    input  logic [1:0]        req_attr,
    input  logic [6:0]        req_laddr,
    input  logic [11:0]       req_bcnt,
    input  logic              tmo_valid,
    input  logic [TAG_W-1:0]  tmo_tag,
    input  logic [DIAG_W-1:0] diag_ctl,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [HDR_W-1:0]  cpl_hdr,
    output logic              fwd_valid,
    output logic [HDR_W-1:0]  fwd_hdr,
    output logic              free_valid,
    output logic [TAG_W-1:0]  free_tag,
    output logic              err_unexp,
    output logic              err_malf,
    output logic              err_retry,
    output logic              err_wuc,
    output logic              err_ruc,
    output logic [HDR_W-1:0]  err_log_hdr
);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } seq_state_e;

    seq_state_e      state_q;
    seq_state_e      state_d;
    cpl_hdr_t        hdr_q;
    pend_ent_t       new_ent;
    pend_ent_t       look_ent;
    verdict_e        verdict;
    cpl_hdr_t        chk_hdr;
    logic            alloc_en;
    logic            retire_en;
    logic [NCHK-1:0] chk_off;
    logic [TAG_W-1:0] cur_tag;

    assign chk_off   = diag_ctl[DIAG_BASE +: NCHK];
    assign cur_tag   = hdr_q.tag[TAG_W-1:0];
    assign cpl_ready = (state_q == ST_IDLE);

    always_comb begin
        new_ent.valid    = 1'b1;
        new_ent.is_write = req_write;
        new_ent.kind     = req_kind_e'(req_kind);
        new_ent.rid      = req_rid;
        new_ent.len      = req_len;
        new_ent.tc       = req_tc;
        new_ent.attr     = req_attr;
        new_ent.laddr    = req_laddr;
        new_ent.bcnt     = req_bcnt;
        alloc_en = req_valid && !(req_write && (req_kind_e'(req_kind) == RK_MEM));
    end

    assign retire_en = (state_q == ST_EVAL) &&
                       ((verdict == VR_GOOD) || (verdict == VR_REMAP));

    cplv_tag_table #(.TAG_W(TAG_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_tag (req_tag),
        .alloc_ent (new_ent),
        .rel_a_en  (retire_en),
        .rel_a_tag (cur_tag),
        .rel_b_en  (tmo_valid),
        .rel_b_tag (tmo_tag),
        .look_tag  (cur_tag),
        .look_ent  (look_ent)
    );

    cplv_field_check #(.TAG_W(TAG_W)) u_check (
        .hdr     (hdr_q),
        .ent     (look_ent),
        .chk_off (chk_off),
        .verdict (verdict),
        .out_hdr (chk_hdr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cpl_valid) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
        endcase
    end

    // state register and header hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hdr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpl_valid) begin
                hdr_q <= cpl_hdr_t'(cpl_hdr);
            end
        end
    end

    // registered verdict outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid   <= 1'b0;
            fwd_hdr     <= '0;
            free_valid  <= 1'b0;
            free_tag    <= '0;
            err_unexp   <= 1'b0;
            err_malf    <= 1'b0;
            err_retry   <= 1'b0;
            err_wuc     <= 1'b0;
            err_ruc     <= 1'b0;
            err_log_hdr <= '0;
        end else begin
            fwd_valid  <= 1'b0;
            free_valid <= 1'b0;
            err_unexp  <= 1'b0;
            err_malf   <= 1'b0;
            err_retry  <= 1'b0;
            err_wuc    <= 1'b0;
            err_ruc    <= 1'b0;
            if (state_q == ST_EVAL) begin
                unique case (verdict)
                    VR_GOOD: begin
                        fwd_valid  <= 1'b1;
                        fwd_hdr    <= chk_hdr;
                        free_valid <= 1'b1;
                        free_tag   <= cur_tag;
                    end
                    VR_UNEXP: begin
                        err_unexp   <= 1'b1;
                        err_log_hdr <= hdr_q;
                    end
                    VR_MALF: begin
                        err_malf    <= 1'b1;
                        err_log_hdr <= hdr_q;
                    end
                    VR_RETRY: begin
                        err_retry   <= 1'b1;
                        err_log_hdr <= hdr_q;
                    end
                    VR_REMAP: begin
                        fwd_valid   <= 1'b1;
                        fwd_hdr     <= chk_hdr;
                        free_valid  <= 1'b1;
                        free_tag    <= cur_tag;
                        err_wuc     <= look_ent.is_write;
                        err_ruc     <= !look_ent.is_write;
                        err_log_hdr <= hdr_q;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cplv_validator_chk.sv
module cplv_validator_chk
    import cplv_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpl_valid,
    input logic             cpl_ready,
    input logic             fwd_valid,
    input logic [HDR_W-1:0] fwd_hdr,
    input logic             free_valid,
    input logic             err_unexp,
    input logic             err_malf,
    input logic             err_retry,
    input logic             err_wuc,
    input logic             err_ruc,
    input logic [HDR_W-1:0] err_log_hdr
);

    logic [4:0] errs;
    assign errs = {err_unexp, err_malf, err_retry, err_wuc, err_ruc};

    // R1: the sequencer leaves IDLE after an accept
    p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> !cpl_ready);

    // R1: a verdict follows every accepted header
    p_verdict_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> ##1 (fwd_valid || err_unexp || err_malf || err_retry));

    // R1: results only come out of the evaluation cycle
    p_fwd_after_eval_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !$past(cpl_ready));

    // R12: one error pulse per completion
    p_one_error_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(errs) <= 1);

    // R12: a forwarded completion never carries a drop verdict
    p_fwd_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !(err_unexp || err_malf || err_retry));

    // R10: a tag is only retired with a forward
    p_free_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |-> fwd_valid);

    // R9: remapped completions are forwarded with UR status
    p_remap_ur_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wuc || err_ruc) |-> (fwd_valid && fwd_hdr[61:59] == CS_UR));

    // R13: the log changes only with an error pulse
    p_log_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (errs == 5'd0) |-> $stable(err_log_hdr));

endmodule

bind cplv_validator cplv_validator_chk #(.TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpl_valid   (cpl_valid),
    .cpl_ready   (cpl_ready),
    .fwd_valid   (fwd_valid),
    .fwd_hdr     (fwd_hdr),
    .free_valid  (free_valid),
    .err_unexp   (err_unexp),
    .err_malf    (err_malf),
    .err_retry   (err_retry),
    .err_wuc     (err_wuc),
    .err_ruc     (err_ruc),
    .err_log_hdr (err_log_hdr)
);

// File: tb/cplv_validator_tb_top.sv
`timescale 1ns/1ps
module cplv_validator_tb_top;
    import cplv_pkg::*;

    localparam int TW = 3;
    localparam int NT = 1 << TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [TW-1:0] req_tag = '0;
    logic req_write = 1'b0;
    logic [1:0] req_kind = '0;
    logic [15:0] req_rid = '0;
    logic [9:0] req_len = '0;
    logic [2:0] req_tc = '0;
    logic [1:0] req_attr = '0;
    logic [6:0] req_laddr = '0;
    logic [11:0] req_bcnt = '0;
    logic tmo_valid = 1'b0;
    logic [TW-1:0] tmo_tag = '0;
    logic [63:0] diag_ctl = '0;
    logic cpl_valid = 1'b0;
    logic cpl_ready;
    logic [95:0] cpl_hdr = '0;
    logic fwd_valid;
    logic [95:0] fwd_hdr;
    logic free_valid;
    logic [TW-1:0] free_tag;
    logic err_unexp, err_malf, err_retry, err_wuc, err_ruc;
    logic [95:0] err_log_hdr;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    pend_ent_t mtab [NT];

    always #2.5 clk = ~clk;

    cplv_validator #(.TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tag(req_tag), .req_write(req_write),
        .req_kind(req_kind), .req_rid(req_rid), .req_len(req_len),
        .req_tc(req_tc), .req_attr(req_attr), .req_laddr(req_laddr),
        .req_bcnt(req_bcnt), .tmo_valid(tmo_valid), .tmo_tag(tmo_tag),
        .diag_ctl(diag_ctl), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .cpl_hdr(cpl_hdr), .fwd_valid(fwd_valid), .fwd_hdr(fwd_hdr),
        .free_valid(free_valid), .free_tag(free_tag),
        .err_unexp(err_unexp), .err_malf(err_malf), .err_retry(err_retry),
        .err_wuc(err_wuc), .err_ruc(err_ruc), .err_log_hdr(err_log_hdr)
    );

    task automatic check(input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // expected verdict from the requirements, using the bench table
    function automatic verdict_e model_verdict(cpl_hdr_t h, logic [4:0] off);
        pend_ent_t e;
        logic cfg, crs, legal, bad;
        e = mtab[h.tag[TW-1:0]];
        if (!e.valid || h.tag[7:TW] != '0 || h.rid != e.rid || h.locked) return VR_UNEXP;
        cfg   = e.kind inside {RK_CFG0, RK_CFG1};
        crs   = h.status == 3'b010;
        legal = h.status inside {3'b000, 3'b001, 3'b010, 3'b100};
        bad   = !legal;
        if (h.has_data != (h.status == 3'b000 && !e.is_write)) bad = 1'b1;
        if (h.has_data && h.len != e.len) bad = 1'b1;
        if (!h.has_data && h.len != 10'd0) bad = 1'b1;
        if (!off[0] && crs && !cfg) bad = 1'b1;
        if (!off[1] && h.tc != e.tc) bad = 1'b1;
        if (!off[2] && h.attr != e.attr) bad = 1'b1;
        if (!off[3] && h.bcnt != e.bcnt) bad = 1'b1;
        if (!off[4] && h.laddr != e.laddr) bad = 1'b1;
        if (bad) return VR_MALF;
        if (crs && cfg) return VR_RETRY;
        if (crs) return VR_REMAP;
        return VR_GOOD;
    endfunction

    function automatic cpl_hdr_t good_cpl(int t);
        cpl_hdr_t h;
        pend_ent_t e;
        e = mtab[t];
        h = '0;
        h.tag      = 8'(t);
        h.rid      = e.rid;
        h.tc       = e.tc;
        h.attr     = e.attr;
        h.laddr    = e.laddr;
        h.bcnt     = e.bcnt;
        h.status   = 3'b000;
        h.has_data = !e.is_write;
        h.len      = e.is_write ? 10'd0 : e.len;
        h.cid      = 16'hC0DE;
        return h;
    endfunction

    // all tasks start and end just after a falling edge
    task automatic issue_req(int t, logic wr, logic [1:0] kind);
        req_valid = 1'b1;
        req_tag   = TW'(t);
        req_write = wr;
        req_kind  = kind;
        req_rid   = 16'($urandom);
        req_len   = 10'($urandom_range(1, 32));
        req_tc    = 3'($urandom);
        req_attr  = 2'($urandom);
        req_laddr = 7'($urandom);
        req_bcnt  = 12'($urandom_range(1, 128));
        if (!(wr && kind == 2'd0)) begin
            mtab[t].valid    = 1'b1;
            mtab[t].is_write = wr;
            mtab[t].kind     = req_kind_e'(kind);
            mtab[t].rid      = req_rid;
            mtab[t].len      = req_len;
            mtab[t].tc       = req_tc;
            mtab[t].attr     = req_attr;
            mtab[t].laddr    = req_laddr;
            mtab[t].bcnt     = req_bcnt;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic timeout(int t);
        tmo_valid = 1'b1;
        tmo_tag   = TW'(t);
        mtab[t].valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        tmo_valid = 1'b0;
    endtask

    task automatic run_cpl(input string rq, input cpl_hdr_t h, input logic [4:0] off,
                           input verdict_e want);
        verdict_e v;
        logic wr;
        logic [6:0] exp_vec, act_vec;
        cpl_hdr_t exp_fwd;
        v  = model_verdict(h, off);
        wr = mtab[h.tag[TW-1:0]].is_write;
        check({rq, " model"}, 128'(v), 128'(want));
        diag_ctl  = 64'(off) << 40;
        cpl_hdr   = h;
        cpl_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b0;
        check("R1 ready low in evaluation", 128'(cpl_ready), 128'(0));
        @(posedge clk);
        @(negedge clk);
        exp_vec = {v == VR_GOOD || v == VR_REMAP, v == VR_UNEXP, v == VR_MALF,
                   v == VR_RETRY, v == VR_REMAP && wr, v == VR_REMAP && !wr,
                   v == VR_GOOD || v == VR_REMAP};
        act_vec = {fwd_valid, err_unexp, err_malf, err_retry, err_wuc, err_ruc, free_valid};
        check({rq, " R12 verdict pulses"}, 128'(act_vec), 128'(exp_vec));
        if (v == VR_GOOD || v == VR_REMAP) begin
            exp_fwd = h;
            if (v == VR_REMAP) exp_fwd.status = 3'b001;
            check({rq, " R10 forwarded header"}, 128'(fwd_hdr), 128'(exp_fwd));
            check({rq, " R10 freed tag"}, 128'(free_tag), 128'(h.tag[TW-1:0]));
            mtab[h.tag[TW-1:0]].valid = 1'b0;
        end
        if (v != VR_GOOD) begin
            check({rq, " R13 error log"}, 128'(err_log_hdr), 128'(h));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        cpl_hdr_t h;
        int seed_dummy;
        seed_dummy = $urandom(20240611);
        for (int i = 0; i < NT; i++) mtab[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R14: reset state
        check("R14 reset outputs", 128'({cpl_ready, fwd_valid, free_valid, err_unexp,
              err_malf, err_retry, err_wuc, err_ruc}), 128'(8'b1000_0000));

        // R3: empty table
        h = good_cpl(2);
        run_cpl("R3 no entry", h, 5'b0, VR_UNEXP);

        // R3 and R10 on a memory read
        issue_req(1, 1'b0, 2'd0);
        h = good_cpl(1); h.locked = 1'b1;
        run_cpl("R3 locked", h, 5'b0, VR_UNEXP);
        h = good_cpl(1); h.rid = h.rid ^ 16'h0100;
        run_cpl("R3 requester mismatch", h, 5'b0, VR_UNEXP);
        h = good_cpl(1); h.tag[6] = 1'b1;
        run_cpl("R3 high tag bit", h, 5'b0, VR_UNEXP);
        h = good_cpl(1);
        run_cpl("R10 good after unexpected", h, 5'b0, VR_GOOD);
        run_cpl("R10 repeat is unexpected", h, 5'b0, VR_UNEXP);

        // R4, R5, R8 on an I/O read
        issue_req(2, 1'b0, 2'd1);
        h = good_cpl(2); h.len = h.len + 10'd1;
        run_cpl("R4 length", h, 5'b0, VR_MALF);
        h = good_cpl(2); h.status = 3'b011;
        run_cpl("R4 illegal status", h, 5'b0, VR_MALF);
        h = good_cpl(2); h.has_data = 1'b0; h.len = 10'd0;
        run_cpl("R4 missing data", h, 5'b0, VR_MALF);
        h = good_cpl(2); h.tc = h.tc ^ 3'd1;
        run_cpl("R5 traffic class", h, 5'b0, VR_MALF);
        h = good_cpl(2); h.bcnt = h.bcnt + 12'd4;
        run_cpl("R5 byte count", h, 5'b00111, VR_MALF);
        run_cpl("R8 byte-count check off", h, 5'b01000, VR_GOOD);

        // R6, R11 on a config read
        issue_req(3, 1'b0, 2'd2);
        h = good_cpl(3); h.status = 3'b010; h.has_data = 1'b0; h.len = 10'd0;
        run_cpl("R6 config retry", h, 5'b0, VR_RETRY);
        timeout(3);
        h = good_cpl(3);
        h.rid = 16'h0; h.tc = 3'd0; h.attr = 2'd0;
        h.rid = mtab[3].rid;
        run_cpl("R11 after timeout", h, 5'b0, VR_UNEXP);

        // R7, R9 on an I/O write
        issue_req(4, 1'b1, 2'd1);
        h = good_cpl(4); h.status = 3'b010;
        run_cpl("R7 CRS on I/O", h, 5'b0, VR_MALF);
        run_cpl("R9 CRS remapped", h, 5'b00001, VR_REMAP);

        // R2: posted memory write
        issue_req(5, 1'b1, 2'd0);
        h = good_cpl(5);
        run_cpl("R2 posted write", h, 5'b0, VR_UNEXP);

        // R12: random traffic
        for (int it = 0; it < 400; it++) begin
            int t, k;
            logic [4:0] off;
            t = $urandom_range(0, NT - 1);
            if (!mtab[t].valid || ($urandom_range(0, 3) == 0))
                issue_req(t, 1'($urandom), 2'($urandom));
            if ($urandom_range(0, 15) == 0) timeout(t);
            h = good_cpl(t);
            k = $urandom_range(0, 12);
            case (k)
                1: h.len = h.len + 10'd1;
                2: h.has_data = ~h.has_data;
                3: h.status = 3'($urandom);
                4: h.tc = h.tc ^ 3'd2;
                5: h.attr = h.attr ^ 2'd1;
                6: h.bcnt = h.bcnt + 12'd8;
                7: h.laddr = h.laddr ^ 7'd1;
                8: h.rid = h.rid ^ 16'h8000;
                9: h.locked = 1'b1;
                10: h.tag[7] = 1'b1;
                11: begin h.status = 3'b010; h.has_data = 1'b0; h.len = 10'd0; end
                default: ;
            endcase
            off = ($urandom_range(0, 1) == 0) ? 5'b0 : 5'($urandom);
            run_cpl("R12 random", h, off, model_verdict(h, off));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule